// File: doc/BRIEF.md
# Rotate/Shift and Bit-Manipulation Unit with Complete Flag Byte

This unit performs the eight single-bit rotate and shift operations of an 8-bit processor's bit-operation group. It also performs the bit test, bit clear and bit set operations of that group. From each result it builds the full flag byte, including the two flag positions that normally carry no defined meaning. Two side inputs let the issuing logic redirect those bits. A compare operation takes them from its operand. A 16-bit arithmetic result takes its sign and both spare bits from its high byte.

The unit also decides where a result is written back. In indexed addressing, a result always goes to memory. It also goes to the register named by the low opcode field, unless that field holds the memory code. The unit performs no memory access itself. It only presents the data together with the write strobes and the register selector.

Each issued operation is captured on the clock edge where `in_valid` is high. All outputs come from registers, so they are due one cycle after issue. Between issues the data outputs hold their values and the strobes stay low.

Top module: `shrot_unit`

## Requirements
- R1: When `grp` is 00, `op_fld` picks the operation: 0 is rotate left circular (bit 7 goes to bit 0), 1 is rotate right circular (bit 0 goes to bit 7), and 2 is rotate left through carry (carry_in enters bit 0). 3 is rotate right through carry (carry_in enters bit 7), 4 is shift left with 0 into bit 0, 5 is shift right keeping bit 7, 6 is shift left with 1 into bit 0, and 7 is shift right with 0 into bit 7.
- R2: Operation 6 always produces a result with bit 0 equal to 1, including for operand 0x00.
- R3: The flag byte is laid out as S=7, Z=6, Y=5, H=4, X=3, P/V=2, N=1, C=0. For a shift or rotate, C holds the bit shifted out, H=0, N=0, Z=1 exactly when the result is zero, P/V=1 when the result has an even number of ones, and S equals result bit 7. `flag_we` is 1.
- R4: With both overrides off, F bits 5 and 3 equal bits 5 and 3 of `result`.
- R5: When `cmp_mode` is 1, F bits 5 and 3 equal bits 5 and 3 of `cmp_operand`. The other flag bits are unaffected.
- R6: When `wide_mode` is 1, F bits 7, 5 and 3 equal bits 7, 5 and 3 of `wide_hi`. If `cmp_mode` is also 1, bits 5 and 3 come from `cmp_operand` while bit 7 still comes from `wide_hi`.
- R7: When `grp` is 01 (bit test of bit `op_fld`), `result` equals the operand. Z and P/V are the inverse of the tested bit, H=1, N=0, C=carry_in, and S=1 only when bit 7 is tested and is 1. Neither `mem_we` nor `reg_we` is raised, whatever `reg_fld` and `idx_mode` are.
- R8: When `grp` is 10, `result` is the operand with bit `op_fld` cleared. When `grp` is 11, that bit is set instead. `flag_we` is 0 for both.
- R9: With `idx_mode`=1 and `grp`≠01, `mem_we`=1. `reg_we`=1 exactly when `reg_fld`≠110. `reg_sel`=`reg_fld`, and `mem_data`=`reg_data`=`result`.
- R10: With `idx_mode`=0 and `grp`≠01, `reg_fld`=110 raises only `mem_we`. Any other value raises only `reg_we`.
- R11: After reset `out_valid`, `flag_we`, `mem_we` and `reg_we` are 0. The outputs of an issue appear on the first rising edge after `in_valid`, and `out_valid` is high for that single cycle. Without `in_valid`, the strobes drop to 0 and the data outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe, captures all inputs |
| grp | input | 2 | Operation group: 00 shift, 01 test, 10 clear, 11 set |
| op_fld | input | 3 | Shift operation or bit index |
| reg_fld | input | 3 | Register field, 110 means memory |
| idx_mode | input | 1 | Indexed addressing form |
| operand | input | 8 | Operand byte |
| carry_in | input | 1 | Current carry flag |
| cmp_mode | input | 1 | Take F bits 5,3 from cmp_operand |
| cmp_operand | input | 8 | Compare operand |
| wide_mode | input | 1 | Take F bits 7,5,3 from wide_hi |
| wide_hi | input | 8 | High byte of a 16-bit result |
| out_valid | output | 1 | Result cycle |
| result | output | 8 | Operation result |
| flag_we | output | 1 | F write strobe |
| f_out | output | 8 | New flag byte |
| mem_we | output | 1 | Memory write strobe |
| mem_data | output | 8 | Memory write data |
| reg_we | output | 1 | Register write strobe |
| reg_sel | output | 3 | Register to write |
| reg_data | output | 8 | Register write data |

## Verification
All results and strobes of an issue appear exactly one cycle after the edge that sees `in_valid`. The bench therefore drives each stimulus on a falling edge and holds `in_valid` for one period. It compares every output on the next falling edge, after exactly one capturing edge. It then drops `in_valid` and waits one more period. At that point it checks that the strobes have fallen and the data outputs still hold the previous values.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SETB  = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    OP_RLC = 3'd0,
    OP_RRC = 3'd1,
    OP_RL  = 3'd2,
    OP_RR  = 3'd3,
    OP_SLA = 3'd4,
    OP_SRA = 3'd5,
    OP_SLL = 3'd6,
    OP_SRL = 3'd7
  } shop_e;

  // packed so that the member order matches F bit 7 down to bit 0
  typedef struct packed {
    logic s;
    logic z;
    logic y;
    logic h;
    logic x;
    logic pv;
    logic n;
    logic c;
  } flags_t;

  localparam logic [2:0] MEM_CODE = 3'b110;

  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction

endpackage

// File: rtl/shrot_shifter.sv
module shrot_shifter
  import shrot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    res  = a;
    cout = 1'b0;
    unique case (shop_e'(op))
      OP_RLC: begin res = {a[MSB-1:0], a[MSB]};  cout = a[MSB]; end
      OP_RRC: begin res = {a[0], a[MSB:1]};      cout = a[0];   end
      OP_RL:  begin res = {a[MSB-1:0], cin};     cout = a[MSB]; end
      OP_RR:  begin res = {cin, a[MSB:1]};       cout = a[0];   end
      OP_SLA: begin res = {a[MSB-1:0], 1'b0};    cout = a[MSB]; end
      OP_SRA: begin res = {a[MSB], a[MSB:1]};    cout = a[0];   end
      OP_SLL: begin res = {a[MSB-1:0], 1'b1};    cout = a[MSB]; end
      OP_SRL: begin res = {1'b0, a[MSB:1]};      cout = a[0];   end
      default: begin res = a; cout = 1'b0; end
    endcase
  end

endmodule

// File: rtl/shrot_bitop.sv
module shrot_bitop
  import shrot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [1:0]        grp,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] res,
  output logic              tested
);
  logic [DATA_W-1:0] sel_mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign sel_mask[g] = (idx == IDX_W'(g));
  end

  assign tested = |(a & sel_mask);

  always_comb begin
    unique case (grp_e'(grp))
      GRP_CLR:  res = a & ~sel_mask;
      GRP_SETB: res = a | sel_mask;
      default:  res = a;
    endcase
  end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        grp,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] res,
  input  logic              shift_out,
  input  logic              tested,
  input  logic              cin,
  input  logic              cmp_mode,
  input  logic [DATA_W-1:0] cmp_operand,
  input  logic              wide_mode,
  input  logic [DATA_W-1:0] wide_hi,
  output flags_t            flags,
  output logic              flag_we
);
  localparam int MSB = DATA_W - 1;

  flags_t base;

  always_comb begin
    base = '0;
    if (grp_e'(grp) == GRP_TEST) begin
      base.s  = (op == 3'd7) && tested;
      base.z  = ~tested;
      base.h  = 1'b1;
      base.pv = ~tested;
      base.n  = 1'b0;
      base.c  = cin;
    end else begin
      base.s  = res[MSB];
      base.z  = (res == '0);
      base.h  = 1'b0;
      base.pv = even_ones(res[7:0]);
      base.n  = 1'b0;
      base.c  = shift_out;
    end
    base.y = res[5];
    base.x = res[3];
  end

  always_comb begin
    flags = base;
    if (wide_mode) begin
      flags.s = wide_hi[MSB];
      flags.y = wide_hi[5];
      flags.x = wide_hi[3];
    end
    if (cmp_mode) begin
      flags.y = cmp_operand[5];
      flags.x = cmp_operand[3];
    end
  end

  assign flag_we = (grp_e'(grp) == GRP_SHIFT) || (grp_e'(grp) == GRP_TEST);

endmodule

// File: rtl/shrot_wb.sv
module shrot_wb
  import shrot_pkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic [1:0]         grp,
  input  logic               idx_mode,
  input  logic [FIELD_W-1:0] reg_fld,
  output logic               mem_we,
  output logic               reg_we
);
  logic writes;
  logic is_mem;

  assign writes = (grp_e'(grp) != GRP_TEST);
  assign is_mem = (reg_fld == FIELD_W'(MEM_CODE));

  always_comb begin
    mem_we = 1'b0;
    reg_we = 1'b0;
    if (writes) begin
      mem_we = idx_mode | is_mem;
      reg_we = ~is_mem;
    end
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         grp,
  input  logic [FIELD_W-1:0] op_fld,
  input  logic [FIELD_W-1:0] reg_fld,
  input  logic               idx_mode,
  input  logic [DATA_W-1:0]  operand,
  input  logic               carry_in,
  input  logic               cmp_mode,
  input  logic [DATA_W-1:0]  cmp_operand,
  input  logic               wide_mode,
  input  logic [DATA_W-1:0]  wide_hi,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result,
  output logic               flag_we,
  output logic [DATA_W-1:0]  f_out,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_data,
  output logic               reg_we,
  output logic [FIELD_W-1:0] reg_sel,
  output logic [DATA_W-1:0]  reg_data
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sh_res, bo_res, res_n;
  logic              sh_out, bo_tested;
  flags_t            fl_n;
  logic              fwe_n, mwe_n, rwe_n;

  shrot_shifter #(.DATA_W(DATA_W)) shifter_i (
    .op(op_fld), .a(operand), .cin(carry_in), .res(sh_res), .cout(sh_out)
  );

  shrot_bitop #(.DATA_W(DATA_W), .IDX_W(FIELD_W)) bitop_i (
    .grp(grp), .idx(op_fld), .a(operand), .res(bo_res), .tested(bo_tested)
  );

  assign res_n = (grp_e'(grp) == GRP_SHIFT) ? sh_res : bo_res;

  shrot_flags #(.DATA_W(DATA_W)) flags_i (
    .grp(grp), .op(op_fld), .res(res_n), .shift_out(sh_out),
    .tested(bo_tested), .cin(carry_in), .cmp_mode(cmp_mode),
    .cmp_operand(cmp_operand), .wide_mode(wide_mode), .wide_hi(wide_hi),
    .flags(fl_n), .flag_we(fwe_n)
  );

  shrot_wb #(.FIELD_W(FIELD_W)) wb_i (
    .grp(grp), .idx_mode(idx_mode), .reg_fld(reg_fld),
    .mem_we(mwe_n), .reg_we(rwe_n)
  );

  // next-state
  logic               vld_d, fwe_d, mwe_d, rwe_d;
  logic [DATA_W-1:0]  res_d, f_d;
  logic [FIELD_W-1:0] sel_d;

  always_comb begin
    vld_d = in_valid;
    fwe_d = in_valid & fwe_n;
    mwe_d = in_valid & mwe_n;
    rwe_d = in_valid & rwe_n;
    res_d = result;
    f_d   = f_out;
    sel_d = reg_sel;
    if (in_valid) begin
      res_d = res_n;
      f_d   = fl_n;
      sel_d = reg_fld;
    end
  end

  // strobes: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flag_we   <= 1'b0;
      mem_we    <= 1'b0;
      reg_we    <= 1'b0;
    end else begin
      out_valid <= vld_d;
      flag_we   <= fwe_d;
      mem_we    <= mwe_d;
      reg_we    <= rwe_d;
    end
  end

  // data path registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      f_out   <= '0;
      reg_sel <= '0;
    end else begin
      result  <= res_d;
      f_out   <= f_d;
      reg_sel <= sel_d;
    end
  end

  assign mem_data = result;
  assign reg_data = result;

  // checks
  assert_strobe_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!flag_we && !mem_we && !reg_we));

  assert_issue_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_sll_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grp == 2'b00 && op_fld == 3'd6) |-> sh_res[0]);

  assert_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grp == 2'b00) |=> (f_out[2] == ~^result));

  assert_test_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grp == 2'b01) |=> (!mem_we && !reg_we && flag_we));

  assert_idx_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && idx_mode && grp != 2'b01) |=> mem_we);

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !idx_mode && grp != 2'b01) |=> (mem_we ^ reg_we));

  assert_setclr_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grp[1]) |=> !flag_we);

  assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grp == 2'b00 && !wide_mode) |=> (f_out[7] == result[MSB]));

endmodule

// File: tb/shrot_unit_tb_top.sv
module shrot_unit_tb_top;
  logic       clk, rst_n, in_valid;
  logic [1:0] grp;
  logic [2:0] op_fld, reg_fld;
  logic       idx_mode, carry_in, cmp_mode, wide_mode;
  logic [7:0] operand, cmp_operand, wide_hi;
  logic       out_valid, flag_we, mem_we, reg_we;
  logic [7:0] result, f_out, mem_data, reg_data;
  logic [2:0] reg_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  shrot_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .grp(grp), .op_fld(op_fld),
    .reg_fld(reg_fld), .idx_mode(idx_mode), .operand(operand), .carry_in(carry_in),
    .cmp_mode(cmp_mode), .cmp_operand(cmp_operand), .wide_mode(wide_mode),
    .wide_hi(wide_hi), .out_valid(out_valid), .result(result), .flag_we(flag_we),
    .f_out(f_out), .mem_we(mem_we), .mem_data(mem_data), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_data(reg_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // independent reference for the shift table
  function automatic logic [8:0] ref_shift(input logic [2:0] op, input logic [7:0] a, input logic ci);
    logic [7:0] r;
    logic       co;
    case (op)
      3'd0: begin r = {a[6:0], a[7]}; co = a[7]; end
      3'd1: begin r = {a[0], a[7:1]}; co = a[0]; end
      3'd2: begin r = {a[6:0], ci};   co = a[7]; end
      3'd3: begin r = {ci, a[7:1]};   co = a[0]; end
      3'd4: begin r = a << 1;         co = a[7]; end
      3'd5: begin r = {a[7], a[7:1]}; co = a[0]; end
      3'd6: begin r = (a << 1) | 8'h01; co = a[7]; end
      default: begin r = a >> 1;      co = a[0]; end
    endcase
    return {co, r};
  endfunction

  task automatic issue(input logic [1:0] g, input logic [2:0] op, input logic [2:0] rf,
                       input logic ix, input logic [7:0] a, input logic ci,
                       input logic cm, input logic [7:0] co, input logic wm,
                       input logic [7:0] wh);
    @(negedge clk);
    grp = g; op_fld = op; reg_fld = rf; idx_mode = ix; operand = a; carry_in = ci;
    cmp_mode = cm; cmp_operand = co; wide_mode = wm; wide_hi = wh; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_shift_all(input logic [7:0] a, input logic ci);
    for (int op = 0; op < 8; op++) begin
      logic [8:0] e;
      logic [7:0] ef;
      e  = ref_shift(3'(op), a, ci);
      ef = {e[7], e[7:0] == 8'h00, e[5], 1'b0, e[3], ~^e[7:0], 1'b0, e[8]};
      issue(2'b00, 3'(op), 3'd7, 1'b0, a, ci, 1'b0, 8'h00, 1'b0, 8'h00);
      check("R1", "result", result, e[7:0]);
      check("R3", "flags", f_out, ef);
      check("R4", "f53", {f_out[5], f_out[3]}, {e[5], e[3]});
      check("R11", "valid", out_valid, 1);
    end
  endtask

  task automatic t_sll_zero;
    issue(2'b00, 3'd6, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R2", "sll of 00", result, 8'h01);
    issue(2'b00, 3'd6, 3'd0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R2", "sll of FF", result, 8'hFF);
    check("R2", "carry", f_out[0], 1);
  endtask

  task automatic t_zero_result;
    issue(2'b00, 3'd4, 3'd0, 1'b0, 8'h80, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R3", "sla 80 flags", f_out, 8'h45);
    check("R3", "sla 80 result", result, 8'h00);
  endtask

  task automatic t_overrides;
    // SRL 0x02 -> 0x01, flags base 0x00
    issue(2'b00, 3'd7, 3'd0, 1'b0, 8'h02, 1'b0, 1'b1, 8'h28, 1'b0, 8'h00);
    check("R5", "cmp 53", f_out, 8'h28);
    issue(2'b00, 3'd7, 3'd0, 1'b0, 8'h02, 1'b0, 1'b0, 8'h00, 1'b1, 8'hA8);
    check("R6", "wide 753", f_out, 8'hA8);
    issue(2'b00, 3'd7, 3'd0, 1'b0, 8'h02, 1'b0, 1'b1, 8'h08, 1'b1, 8'hA0);
    check("R6", "cmp wins 53", f_out, 8'h88);
    check("R6", "result kept", result, 8'h01);
  endtask

  task automatic t_bit_test;
    for (int f = 0; f < 8; f++) begin
      issue(2'b01, 3'd7, 3'(f), 1'b1, 8'h80, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
      check("R7", "no mem", mem_we, 0);
      check("R7", "no reg", reg_we, 0);
      check("R7", "flags b7 set", f_out, 8'h91);
    end
    issue(2'b01, 3'd3, 3'd0, 1'b0, 8'h20, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R7", "flags b3 clear", f_out, 8'h74);
    check("R7", "result", result, 8'h20);
    check("R7", "flag_we", flag_we, 1);
  endtask

  task automatic t_set_clr;
    issue(2'b10, 3'd4, 3'd1, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R8", "clear b4", result, 8'hEF);
    check("R8", "no flag", flag_we, 0);
    issue(2'b11, 3'd0, 3'd1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R8", "set b0", result, 8'h01);
    check("R8", "no flag", flag_we, 0);
  endtask

  task automatic t_writeback;
    issue(2'b00, 3'd0, 3'd3, 1'b1, 8'h81, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R9", "mem_we", mem_we, 1);
    check("R9", "reg_we", reg_we, 1);
    check("R9", "reg_sel", reg_sel, 3);
    check("R9", "mem_data", mem_data, 8'h03);
    check("R9", "reg_data", reg_data, 8'h03);
    issue(2'b11, 3'd7, 3'd6, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R9", "idx field 110 mem", mem_we, 1);
    check("R9", "idx field 110 reg", reg_we, 0);
    check("R9", "data", mem_data, 8'h80);
    issue(2'b00, 3'd1, 3'd6, 1'b0, 8'h01, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R10", "mem only mem", mem_we, 1);
    check("R10", "mem only reg", reg_we, 0);
    issue(2'b10, 3'd1, 3'd2, 1'b0, 8'h02, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R10", "reg only mem", mem_we, 0);
    check("R10", "reg only reg", reg_we, 1);
    check("R10", "reg_sel", reg_sel, 2);
  endtask

  task automatic t_hold;
    issue(2'b00, 3'd5, 3'd1, 1'b0, 8'h84, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R1", "sra keeps b7", result, 8'hC2);
    operand = 8'h00;
    @(negedge clk);
    check("R11", "valid low", out_valid, 0);
    check("R11", "reg_we low", reg_we, 0);
    check("R11", "flag_we low", flag_we, 0);
    check("R11", "result held", result, 8'hC2);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; grp = 2'b00; op_fld = 3'd0; reg_fld = 3'd0;
    idx_mode = 1'b0; operand = 8'h00; carry_in = 1'b0; cmp_mode = 1'b0;
    cmp_operand = 8'h00; wide_mode = 1'b0; wide_hi = 8'h00;
    repeat (3) @(negedge clk);
    check("R11", "reset valid", out_valid, 0);
    check("R11", "reset strobes", {flag_we, mem_we, reg_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_shift_all(8'h81, 1'b0);
    t_shift_all(8'h5A, 1'b1);
    t_shift_all(8'h28, 1'b1);
    t_sll_zero;
    t_zero_result;
    t_overrides;
    t_bit_test;
    t_set_clr;
    t_writeback;
    t_hold;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule